// File: doc/BRIEF.md
# Serial Link Data Valid Detector

This block watches a recovered serial bit stream from an 8b/10b-coded link and decides whether the stream carries legal link data. It accepts one bit per clock when a bit-valid strobe is high. Two checks run on every accepted bit. The first looks for runs of identical bits that are too long. The second looks for a comma pattern. An internal free-running counter divides the accepted bits into fixed frames. At the end of each frame the block judges that frame good or bad.

The per-frame verdict feeds a hysteresis filter. A mode input selects between two behaviours. In one, the output follows each frame. In the other, the output changes state only after four consecutive frames that disagree with it. The registered data-valid output is meant to steer a bypass multiplexer elsewhere on the chip, so that a port sending garbage is switched out of the loop. Only the comma pattern is recognised; the block does no full 8b/10b decoding.

Top module: `serial_dv_detect`

## Requirements
- R1: A frame is 2^FRAME_LOG2 accepted bits (32768 by default), counted from reset. `data_valid` changes only on the clock edge that accepts the last bit of a frame.
- R2: A frame is bad if six or more consecutive accepted bits have the same value anywhere in it. A run of five is allowed.
- R3: A comma is the 7-bit sequence 0011111 or 1100000, oldest bit first, at any bit alignment. A frame in which no comma completes is bad. A frame is good only when it has a comma and no run-length violation.
- R4: Run-length and comma tracking carry across frame boundaries. An event is charged to the frame in which its final bit arrives. The per-frame error flags clear at every boundary.
- R5: Cycles with `bit_vld` low have no effect, whatever the value on `bit_in`.
- R6: With `multi_frame` low at a boundary, `data_valid` becomes 1 after a good frame and 0 after a bad frame. Both consecutive-frame counters are held at zero.
- R7: With `multi_frame` high at a boundary, `data_valid` rises only after four consecutive good frames and falls only after four consecutive bad frames. A good frame clears the bad count, and a bad frame clears the good count.
- R8: After reset, `data_valid` is 0 and the frame counter and both consecutive-frame counters are 0. A comma needs seven accepted bits after reset before it can complete.
- R9: `multi_frame` is sampled only on the boundary cycle. A change takes effect at the next frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_vld | input | 1 | High when `bit_in` holds a recovered bit |
| bit_in | input | 1 | Recovered serial data bit |
| multi_frame | input | 1 | 0: single-frame filter, 1: four-frame filter |
| data_valid | output | 1 | Registered link-data-valid verdict |

## Verification
The hardest case to reach from the ports is an error or a comma that straddles a frame boundary. In that case a frame is judged by bits that partly belong to its neighbour. The stimulus builds frames bit by bit. In one pair, a comma starts in the last three bits of a comma-free frame, and that frame must be judged bad while the next one is judged good. In another pair, a run of four ones at a frame's end joins three ones at the next frame's start, and only the later frame must be judged bad. Idle cycles carrying random `bit_in` values are spread through every frame, and frames that disagree with the output are mixed in four-frame mode, so that counter clearing is exercised on both sides.

// File: rtl/dv_pkg.sv
package dv_pkg;
  localparam int unsigned COMMA_W = 7;
  // Oldest bit in the MSB position.
  localparam logic [COMMA_W-1:0] COMMA_POS = 7'b0011111;
  localparam logic [COMMA_W-1:0] COMMA_NEG = 7'b1100000;

  typedef enum logic {FILT_SINGLE = 1'b0, FILT_MULTI = 1'b1} filt_mode_e;
endpackage

// File: rtl/dv_run_check.sv
module dv_run_check #(
  parameter int unsigned RUN_MAX = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic run_err
);
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 2);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(RUN_MAX + 1);

  logic             last_q;
  logic [RUN_W-1:0] len_q, len_d;

  always_comb begin
    if (bit_in != last_q)      len_d = RUN_W'(1);
    else if (len_q == RUN_SAT) len_d = len_q;
    else                       len_d = len_q + RUN_W'(1);
  end

  assign run_err = bit_vld && (len_d == RUN_SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      len_q  <= '0;
    end else if (bit_vld) begin
      last_q <= bit_in;
      len_q  <= len_d;
    end
  end
endmodule

// File: rtl/dv_comma_check.sv
module dv_comma_check
  import dv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic comma_hit
);
  localparam int unsigned FILL_W = $clog2(COMMA_W + 1);

  logic [COMMA_W-1:0] sh_q, sh_d;
  logic [FILL_W-1:0]  fill_q, fill_d;
  logic               full;

  always_comb begin
    sh_d   = {sh_q[COMMA_W-2:0], bit_in};
    full   = (fill_q >= FILL_W'(COMMA_W - 1));
    fill_d = (fill_q == FILL_W'(COMMA_W)) ? fill_q : fill_q + FILL_W'(1);
  end

  assign comma_hit = bit_vld && full && ((sh_d == COMMA_POS) || (sh_d == COMMA_NEG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (bit_vld) begin
      sh_q   <= sh_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/dv_frame_eval.sv
module dv_frame_eval #(
  parameter int unsigned FRAME_LOG2 = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic run_err,
  input  logic comma_hit,
  output logic frame_end,
  output logic frame_good
);
  logic [FRAME_LOG2-1:0] pos_q;
  logic                  err_seen_q, comma_seen_q;
  logic                  err_seen_d, comma_seen_d;

  assign frame_end  = bit_vld && (&pos_q);
  assign frame_good = !(err_seen_q || run_err) && (comma_seen_q || comma_hit);

  always_comb begin
    err_seen_d   = err_seen_q;
    comma_seen_d = comma_seen_q;
    if (frame_end) begin
      err_seen_d   = 1'b0;
      comma_seen_d = 1'b0;
    end else if (bit_vld) begin
      err_seen_d   = err_seen_q   || run_err;
      comma_seen_d = comma_seen_q || comma_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q        <= '0;
      err_seen_q   <= 1'b0;
      comma_seen_q <= 1'b0;
    end else begin
      if (bit_vld) pos_q <= pos_q + 1'b1;
      err_seen_q   <= err_seen_d;
      comma_seen_q <= comma_seen_d;
    end
  end
endmodule

// File: rtl/dv_frame_filter.sv
module dv_frame_filter
  import dv_pkg::*;
#(
  parameter int unsigned MULTI_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_end,
  input  logic       frame_good,
  input  filt_mode_e mode,
  output logic       dv,
  output logic [$clog2(MULTI_N)-1:0] good_run,
  output logic [$clog2(MULTI_N)-1:0] bad_run
);
  localparam int unsigned CNT_W = $clog2(MULTI_N);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MULTI_N - 1);

  logic             dv_q, dv_d;
  logic [CNT_W-1:0] good_q, good_d, bad_q, bad_d;

  always_comb begin
    dv_d   = dv_q;
    good_d = good_q;
    bad_d  = bad_q;
    if (frame_end) begin
      if (mode == FILT_SINGLE) begin
        dv_d   = frame_good;
        good_d = '0;
        bad_d  = '0;
      end else if (frame_good) begin
        bad_d = '0;
        if (!dv_q) begin
          if (good_q == LAST) begin
            dv_d   = 1'b1;
            good_d = '0;
          end else begin
            good_d = good_q + CNT_W'(1);
          end
        end
      end else begin
        good_d = '0;
        if (dv_q) begin
          if (bad_q == LAST) begin
            dv_d  = 1'b0;
            bad_d = '0;
          end else begin
            bad_d = bad_q + CNT_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q   <= 1'b0;
      good_q <= '0;
      bad_q  <= '0;
    end else begin
      dv_q   <= dv_d;
      good_q <= good_d;
      bad_q  <= bad_d;
    end
  end

  assign dv       = dv_q;
  assign good_run = good_q;
  assign bad_run  = bad_q;
endmodule

// File: rtl/serial_dv_detect.sv
module serial_dv_detect
  import dv_pkg::*;
#(
  parameter int unsigned FRAME_LOG2 = 15,
  parameter int unsigned RUN_MAX    = 5,
  parameter int unsigned MULTI_N    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic multi_frame,
  output logic data_valid
);
  localparam int unsigned CNT_W = $clog2(MULTI_N);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             run_err, comma_hit, frame_end, frame_good;
  logic [CNT_W-1:0] good_run, bad_run;
  filt_mode_e       mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];
  assign mode      = multi_frame ? FILT_MULTI : FILT_SINGLE;

  dv_run_check #(.RUN_MAX(RUN_MAX)) i_run (
    .clk(clk), .rst_n(rst_int_n), .bit_vld(bit_vld), .bit_in(bit_in), .run_err(run_err)
  );

  dv_comma_check i_comma (
    .clk(clk), .rst_n(rst_int_n), .bit_vld(bit_vld), .bit_in(bit_in), .comma_hit(comma_hit)
  );

  dv_frame_eval #(.FRAME_LOG2(FRAME_LOG2)) i_eval (
    .clk(clk), .rst_n(rst_int_n), .bit_vld(bit_vld), .run_err(run_err),
    .comma_hit(comma_hit), .frame_end(frame_end), .frame_good(frame_good)
  );

  dv_frame_filter #(.MULTI_N(MULTI_N)) i_filt (
    .clk(clk), .rst_n(rst_int_n), .frame_end(frame_end), .frame_good(frame_good),
    .mode(mode), .dv(data_valid), .good_run(good_run), .bad_run(bad_run)
  );
endmodule

// File: rtl/serial_dv_detect_chk.sv
module serial_dv_detect_chk #(
  parameter int unsigned MULTI_N = 4
) (
  input logic clk,
  input logic rst_int_n,
  input logic bit_vld,
  input logic multi_frame,
  input logic run_err,
  input logic comma_hit,
  input logic frame_end,
  input logic frame_good,
  input logic data_valid,
  input logic [$clog2(MULTI_N)-1:0] good_run,
  input logic [$clog2(MULTI_N)-1:0] bad_run
);
  // R1
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !frame_end |=> $stable(data_valid));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bit_vld |-> !(run_err || comma_hit || frame_end));

  // R6
  single_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frame_end && !multi_frame) |=> (data_valid == $past(frame_good)));

  // R7
  multi_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frame_end && multi_frame && data_valid && !frame_good && bad_run == '0) |=> data_valid);

  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (good_run < MULTI_N) && (bad_run < MULTI_N) && !(good_run != '0 && bad_run != '0));

  // R8
  reset_low_chk: assert property (@(posedge clk)
    !rst_int_n |-> !data_valid);
endmodule

bind serial_dv_detect serial_dv_detect_chk #(.MULTI_N(MULTI_N)) i_chk (
  .clk(clk), .rst_int_n(rst_int_n), .bit_vld(bit_vld), .multi_frame(multi_frame),
  .run_err(run_err), .comma_hit(comma_hit), .frame_end(frame_end),
  .frame_good(frame_good), .data_valid(data_valid), .good_run(good_run), .bad_run(bad_run)
);

// File: tb/test_serial_dv_detect.sv
module test_serial_dv_detect;
  localparam int FL = 6;
  localparam int FB = 1 << FL;

  localparam int K_GOOD = 0, K_NOCOMMA = 1, K_RLV = 2, K_SPLIT_A = 3,
                 K_SPLIT_B = 4, K_TAIL_C = 5, K_HEAD_D = 6;

  logic clk = 1'b0;
  logic rst_n, bit_vld, bit_in, multi_frame, data_valid;

  int checks = 0, fails = 0;
  int bits_seen = 0;
  bit frame_done = 1'b0;
  bit done = 1'b0;
  bit exp_q[$];
  string tag_q[$];

  bit m_dv = 1'b0;
  int m_good = 0, m_bad = 0;

  always #4 clk = ~clk;

  serial_dv_detect #(.FRAME_LOG2(FL)) i_serial_dv_detect (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .multi_frame(multi_frame), .data_valid(data_valid)
  );

  function automatic logic [FB-1:0] make_frame(int kind);
    logic [FB-1:0] f;
    for (int k = 0; k < FB; k++) begin
      case (kind)
        K_NOCOMMA, K_SPLIT_A: f[k] = (k % 2 == 0);
        K_SPLIT_B: f[k] = (k < 4) ? 1'b1 : ((k - 4) % 2 == 1);
        K_HEAD_D:  f[k] = (k < 3) ? 1'b1 : (k < 5) ? 1'b0 : (k < 10) ? 1'b1 : ((k - 10) % 2 == 1);
        default:   f[k] = (k < 2) ? 1'b0 : (k < 7) ? 1'b1 : ((k - 7) % 2 == 1);
      endcase
    end
    if (kind == K_RLV)     for (int k = 20; k < 26; k++) f[k] = 1'b1;
    if (kind == K_SPLIT_A) begin f[FB-2] = 1'b0; f[FB-1] = 1'b1; end
    if (kind == K_TAIL_C)  for (int k = FB-3; k < FB; k++) f[k] = 1'b1;
    return f;
  endfunction

  function automatic bit kind_good(int kind);
    return (kind == K_GOOD || kind == K_SPLIT_B || kind == K_TAIL_C);
  endfunction

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: data_valid=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Driver: predicts the verdict, queues it, then sends the bits with idle gaps.
  task automatic send_frame(int kind, bit multi, string tag);
    logic [FB-1:0] f;
    bit g;
    f = make_frame(kind);
    g = kind_good(kind);
    if (!multi) begin
      m_dv = g; m_good = 0; m_bad = 0;
    end else if (g) begin
      m_bad = 0;
      if (!m_dv) begin
        if (m_good == 3) begin m_dv = 1'b1; m_good = 0; end else m_good++;
      end
    end else begin
      m_good = 0;
      if (m_dv) begin
        if (m_bad == 3) begin m_dv = 1'b0; m_bad = 0; end else m_bad++;
      end
    end
    exp_q.push_back(m_dv);
    tag_q.push_back(tag);
    for (int k = 0; k < FB; k++) begin
      if (k % 5 == 2) begin
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'(($urandom() >> 3) & 1);   // R5 garbage on idle cycle
        multi_frame = multi;
      end
      @(negedge clk);
      bit_vld = 1'b1;
      bit_in  = f[k];
      multi_frame = multi;
      if (k == FB/2 && kind == K_GOOD && multi) multi_frame = 1'b0; // R9 mid-frame glitch
      if (k == FB/2 + 1) multi_frame = multi;
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && bit_vld) begin
      bits_seen++;
      if (bits_seen % FB == 0) frame_done = 1'b1;
    end
  end

  // Monitor: pops one expected verdict per completed frame.
  initial begin
    forever begin
      @(negedge clk);
      if (frame_done) begin
        frame_done = 1'b0;
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R1: frame ended with no prediction queued, actual=%0b expected=none", data_valid);
        end else begin
          check(tag_q.pop_front(), data_valid, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; multi_frame = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset", data_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 after release", data_valid, 1'b0);
    // Single-frame mode.
    send_frame(K_GOOD,    1'b0, "R8/R6 first frame good");
    send_frame(K_NOCOMMA, 1'b0, "R3 no comma");
    send_frame(K_GOOD,    1'b0, "R6 good again");
    send_frame(K_RLV,     1'b0, "R2 run of seven");
    send_frame(K_SPLIT_A, 1'b0, "R4 comma starts late");
    send_frame(K_SPLIT_B, 1'b0, "R4 comma completes here");
    send_frame(K_TAIL_C,  1'b0, "R2 run of four at end");
    send_frame(K_HEAD_D,  1'b0, "R4 run joins across boundary");
    send_frame(K_GOOD,    1'b0, "R6 recover");
    // Four-frame mode.
    send_frame(K_NOCOMMA, 1'b1, "R7 bad 1 holds");
    send_frame(K_NOCOMMA, 1'b1, "R7 bad 2 holds");
    send_frame(K_NOCOMMA, 1'b1, "R7 bad 3 holds");
    send_frame(K_GOOD,    1'b1, "R7 good clears bad count");
    send_frame(K_NOCOMMA, 1'b1, "R7 bad 1 after clear");
    send_frame(K_RLV,     1'b1, "R7 bad 2 after clear");
    send_frame(K_NOCOMMA, 1'b1, "R7 bad 3 after clear");
    send_frame(K_NOCOMMA, 1'b1, "R7 bad 4 falls");
    send_frame(K_GOOD,    1'b1, "R9 good 1 holds low");
    send_frame(K_GOOD,    1'b1, "R7 good 2 holds low");
    send_frame(K_GOOD,    1'b1, "R7 good 3 holds low");
    send_frame(K_NOCOMMA, 1'b1, "R7 bad clears good count");
    send_frame(K_GOOD,    1'b1, "R7 good 1 again");
    send_frame(K_GOOD,    1'b1, "R7 good 2 again");
    send_frame(K_GOOD,    1'b1, "R7 good 3 again");
    send_frame(K_GOOD,    1'b1, "R7 good 4 rises");
    // Back to single-frame mode.
    send_frame(K_NOCOMMA, 1'b0, "R9 single mode drops at once");
    @(negedge clk);
    bit_vld = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 stable while idle", data_valid, m_dv);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule